// File: doc/BRIEF.md
# Vector Priority Interrupt Controller

This block sits beside a processor core and decides which queued interrupt vector the core should take next. Vectors arrive one per cycle on an accept strobe and are held in a 256-entry pending register, one bit per vector. A 256-entry in-service register records every vector the core has taken and not yet retired, which lets interrupts nest. Software sets a task-priority value that masks low-urgency work.

Each 8-bit vector's upper nibble is its priority class. Only the class matters for arbitration, and class 15 is the most urgent. A derived processor-priority value combines the task priority with the class of the most urgent vector in service. The pending line rises only when the most urgent pending vector's class is strictly above the processor-priority class. When the core acknowledges, that vector moves from pending to in service and appears on the vector output. An end-of-interrupt write retires the most urgent in-service vector.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset, no vector is pending or in service, the task priority is 0x00, `irq_o` is low and `ppr_o` reads 0x00.
- R2: An accept strobe with a vector from 32 to 255 makes that vector pending. `irq_o` reflects it in the cycle after the strobe.
- R3: An accept strobe with a vector from 0 to 31 changes no state. `irq_o` stays low and a following acknowledge is spurious.
- R4: The class of a vector is bits [7:4]. `irq_o` is never high unless the most urgent pending class is strictly greater than the task-priority class (`tpr` bits [7:4]).
- R5: `ppr_o` equals the task priority when the task-priority class is at least the class of the most urgent in-service vector. Otherwise it equals that in-service class with bits [3:0] zero.
- R6: `irq_o` is high exactly when a vector is pending and its class exceeds `ppr_o` bits [7:4]. A pending vector of the same class as one in service is therefore held back.
- R7: While `irq_o` is high, `ack_vec_o` shows the highest-numbered pending vector. An acknowledge in that cycle clears the vector's pending bit and sets its in-service bit from the next cycle.
- R8: An acknowledge while `irq_o` is low changes no state, and `ack_vec_o` then reads the spurious code 0xFF.
- R9: An end-of-interrupt clears only the highest-numbered set in-service bit. It has no effect when nothing is in service.
- R10: A vector already in service may become pending once more. Repeated strobes of a pending vector merge into one request that needs only one acknowledge.
- R11: A vector of a higher class than every in-service vector raises `irq_o` and nests over the running one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Accept strobe for `req_vec_i` |
| req_vec_i | input | 8 | Incoming vector number |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| eoi_i | input | 1 | End-of-interrupt write |
| tpr_we_i | input | 1 | Task-priority write enable |
| tpr_i | input | 8 | Task-priority write data |
| irq_o | output | 1 | Interrupt pending toward the core |
| ack_vec_o | output | 8 | Vector delivered on acknowledge (0xFF when none) |
| ppr_o | output | 8 | Current processor priority |

## Verification
The hardest situation to reach is a vector that is in service and pending again while a higher-class vector is nested on top of it. In that state, three separate gates (task priority, in-service class and pending class) all bear on `irq_o`. The stimulus builds it in order: take a class-4 vector, post a second vector of the same class and the same vector again, nest a class-8 vector, then retire vectors one at a time. After each retire it checks which request is released. Full sweeps cover every vector number and every pairing of task-priority class with pending class.

// File: rtl/vec_prio_pkg.sv
package vec_prio_pkg;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned CLS_W   = 4;
  localparam int unsigned NUM_VEC = 1 << VEC_W;
  localparam int unsigned NUM_CLS = 1 << CLS_W;
  localparam int unsigned GRP_SZ  = NUM_VEC / NUM_CLS;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t cls_of(vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction
endpackage

// File: rtl/vec_find_top.sv
module vec_find_top
  import vec_prio_pkg::*;
(
  input  logic [NUM_VEC-1:0] bits_i,
  output logic               found_o,
  output vec_t               idx_o
);
  localparam int unsigned LW = VEC_W - CLS_W;

  logic [NUM_CLS-1:0] grp_any;
  logic [GRP_SZ-1:0]  grp_bits;
  cls_t               top_g;
  logic [LW-1:0]      top_l;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_grp
    assign grp_any[g] = |bits_i[g*GRP_SZ +: GRP_SZ];
  end

  // two-level search: class group first, then position inside it
  always_comb begin
    top_g = '0;
    for (int g = 0; g < NUM_CLS; g++)
      if (grp_any[g]) top_g = CLS_W'(g);
    grp_bits = bits_i[top_g*GRP_SZ +: GRP_SZ];
    top_l = '0;
    for (int l = 0; l < GRP_SZ; l++)
      if (grp_bits[l]) top_l = LW'(l);
  end

  assign found_o = |grp_any;
  assign idx_o   = {top_g, top_l};
endmodule

// File: rtl/vec_bank.sv
module vec_bank
  import vec_prio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  vec_t               set_idx_i,
  input  logic               clr_en_i,
  input  vec_t               clr_idx_i,
  output logic [NUM_VEC-1:0] bits_o
);
  logic [NUM_VEC-1:0] set_mask, clr_mask, bits_q;

  assign set_mask = set_en_i ? (NUM_VEC'(1) << set_idx_i) : '0;
  assign clr_mask = clr_en_i ? (NUM_VEC'(1) << clr_idx_i) : '0;

  // set wins over clear so a re-arrival during retirement is kept
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= (bits_q & ~clr_mask) | set_mask;

  assign bits_o = bits_q;
endmodule

// File: rtl/vec_prio_calc.sv
module vec_prio_calc
  import vec_prio_pkg::*;
(
  input  vec_t tpr_i,
  input  logic isr_found_i,
  input  vec_t isr_top_i,
  input  logic irr_found_i,
  input  vec_t irr_top_i,
  output vec_t ppr_o,
  output logic irq_o
);
  cls_t isr_cls;

  always_comb begin
    isr_cls = isr_found_i ? cls_of(isr_top_i) : '0;
    if (cls_of(tpr_i) >= isr_cls) ppr_o = tpr_i;
    else                          ppr_o = {isr_cls, {(VEC_W-CLS_W){1'b0}}};
    irq_o = irr_found_i && (cls_of(irr_top_i) > cls_of(ppr_o));
  end
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vec_prio_pkg::*;
#(
  parameter int unsigned RSVD_VEC = 32,
  parameter vec_t        SPUR_VEC = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [VEC_W-1:0] ppr_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q;
  vec_t tpr_q, irr_top, isr_top, ppr;
  logic irr_found, isr_found, irq, accept, take, retire;

  assign accept = req_valid_i && (req_vec_i >= VEC_W'(RSVD_VEC));
  assign take   = ack_i && irq;
  assign retire = eoi_i && isr_found;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       tpr_q <= '0;
    else if (tpr_we_i) tpr_q <= tpr_i;

  vec_bank u_irr (
    .clk_i, .rst_ni,
    .set_en_i(accept), .set_idx_i(req_vec_i),
    .clr_en_i(take),   .clr_idx_i(irr_top),
    .bits_o(irr_q)
  );

  vec_bank u_isr (
    .clk_i, .rst_ni,
    .set_en_i(take),   .set_idx_i(irr_top),
    .clr_en_i(retire), .clr_idx_i(isr_top),
    .bits_o(isr_q)
  );

  vec_find_top u_irr_top (.bits_i(irr_q), .found_o(irr_found), .idx_o(irr_top));
  vec_find_top u_isr_top (.bits_i(isr_q), .found_o(isr_found), .idx_o(isr_top));

  vec_prio_calc u_calc (
    .tpr_i(tpr_q),
    .isr_found_i(isr_found), .isr_top_i(isr_top),
    .irr_found_i(irr_found), .irr_top_i(irr_top),
    .ppr_o(ppr), .irq_o(irq)
  );

  assign irq_o     = irq;
  assign ppr_o     = ppr;
  assign ack_vec_o = irq ? irr_top : SPUR_VEC;

  p_rsvd_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !accept && !ack_i) |=> irr_q == $past(irr_q));

  p_irq_above_tpr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cls_of(ack_vec_o) > cls_of(tpr_q));

  p_ppr_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_q);

  p_ack_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> isr_q[$past(ack_vec_o)]);

  p_spur_nochange_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !req_valid_i && !eoi_i) |=> (isr_q == $past(isr_q)) && (irr_q == $past(irr_q)));

  p_eoi_one_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: tb/vec_prio_ctrl_test.sv
module vec_prio_ctrl_test;
  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, ack = 0, eoi = 0, tpr_we = 0;
  logic [7:0] req_vec = 0, tpr = 0;
  logic irq;
  logic [7:0] ack_vec, ppr;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vec_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_vec_i(req_vec),
    .ack_i(ack), .eoi_i(eoi),
    .tpr_we_i(tpr_we), .tpr_i(tpr),
    .irq_o(irq), .ack_vec_o(ack_vec), .ppr_o(ppr)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic post(int v);
    req_valid = 1; req_vec = 8'(v); tick(); req_valid = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic do_eoi();
    eoi = 1; tick(); eoi = 0;
  endtask

  task automatic set_tpr(int t);
    tpr_we = 1; tpr = 8'(t); tick(); tpr_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1; tick();
    check("R1 irq", irq, 0);
    check("R1 ppr", ppr, 0);
    check("R1 vec", ack_vec, 8'hFF);

    // every vector number, one at a time
    for (int v = 0; v < 256; v++) begin
      post(v);
      if (v >= 32) begin
        check("R2 irq", irq, 1);
        check("R7 vec", ack_vec, v);
        do_ack();
        check("R7 irq after ack", irq, 0);
        check("R5 ppr in service", ppr, (v & 8'hF0));
        do_eoi();
        check("R9 ppr after eoi", ppr, 0);
      end else begin
        check("R3 irq", irq, 0);
        check("R8 spurious vec", ack_vec, 8'hFF);
        do_ack();
        check("R8 irq", irq, 0);
        check("R8 ppr", ppr, 0);
      end
    end

    // task priority class against pending class
    for (int t = 0; t < 16; t++) begin
      for (int c = 2; c < 16; c++) begin
        set_tpr(t * 16 + 9);
        check("R5 ppr eq tpr", ppr, t * 16 + 9);
        post(c * 16 + 3);
        check("R4 gate", irq, (c > t) ? 1 : 0);
        set_tpr(0);
        check("R6 released", irq, 1);
        do_ack();
        do_eoi();
        check("R9 empty", irq, 0);
      end
    end

    // nesting, same-class hold-off, re-pend of in-service vector
    post(8'h45); do_ack();
    check("R5 ppr isr", ppr, 8'h40);
    set_tpr(8'h37);
    check("R5 isr above tpr", ppr, 8'h40);
    set_tpr(8'h5A);
    check("R5 tpr above isr", ppr, 8'h5A);
    set_tpr(0);
    post(8'h47);
    check("R6 same class held", irq, 0);
    post(8'h45); post(8'h45);
    check("R10 re-pend held", irq, 0);
    post(8'h80);
    check("R11 nest irq", irq, 1);
    check("R11 nest vec", ack_vec, 8'h80);
    do_ack();
    check("R11 ppr", ppr, 8'h80);
    do_eoi();
    check("R9 top retired", ppr, 8'h40);
    check("R6 still held", irq, 0);
    do_eoi();
    check("R9 all retired", ppr, 0);
    check("R10 irq", irq, 1);
    check("R7 highest first", ack_vec, 8'h47);
    do_ack();
    check("R6 held by 47", irq, 0);
    do_eoi();
    check("R10 vec", ack_vec, 8'h45);
    do_ack(); do_eoi();
    check("R10 merged", irq, 0);
    do_eoi();
    check("R9 eoi when empty", ppr, 0);
    check("R8 idle vec", ack_vec, 8'hFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule